// File: doc/BRIEF.md
# Two-Thread Fetch Selection and Decode Gating Controller

This block decides, every cycle, which of two hardware threads of a simultaneous-multithreading core may fetch, which may decode, and which thread's instruction group goes to dispatch. Software gives each thread a 3-bit priority. A thread whose share of the reorder buffer has grown past a programmable group threshold is pushed down to the lowest live priority. Decode for a thread is held off while that thread has level-2 misses outstanding. A long-latency operation stalls the thread's decode until that operation completes, and it raises a one-cycle partial-flush request tagged with the thread.

The reorder buffer is not stored here. It is modelled as one group counter per thread. A counter rises when the dispatch handshake completes and falls on a retire pulse. The buffer holds 20 groups in total. Dispatch leaves through a valid/ready pair. `disp_valid` is an offer for the current cycle only: a stall, a miss or a full buffer can withdraw it, and `disp_tid` can change, before `disp_ready` is seen. A group counts as accepted only in a cycle in which both `disp_valid` and `disp_ready` are high. While `disp_ready` stays low, nothing is allocated and the offer is made again.

Top module: `smt_thread_ctl`

## Requirements
- R1: In any cycle where at least one thread has a nonzero priority, `fetch_vld` is 1. In any cycle where both priorities are 0, `fetch_vld` is 0. A thread with priority 0 is never granted fetch or dispatch.
- R2: Between two requesting threads, the one with the higher effective priority wins. When the effective priorities are equal, the grant alternates from cycle to cycle. After reset, the first tied fetch grant goes to thread 0 (tid 0).
- R3: Reset sets both priorities to 4, both group counts to 0 and the threshold to 12. Reset also clears all stalls and pending flushes.
- R4: A thread whose group count is strictly greater than the threshold has an effective priority of 1. A count equal to the threshold leaves the thread's priority unchanged. A threshold write takes effect in the cycle after the write.
- R5: `dec_en[t]` is 0 whenever thread t has a nonzero L2 miss count or a priority of 0. The miss-count input is combinational, so the gating applies in the same cycle.
- R6: A `longlat_start[t]` pulse drops `dec_en[t]` from the next cycle onward. `dec_en[t]` stays low until the cycle after a `longlat_done[t]` pulse. If start and done arrive in the same cycle, start wins.
- R7: In the cycle after `longlat_start[t]`, `flush_vld` pulses for one cycle with `flush_tid` equal to t. If both threads start together, the thread 0 flush comes first and the thread 1 flush follows in the next cycle.
- R8: `disp_valid` is offered only for a thread that has `dec_en` high and `grp_avail` high. Dispatch uses the R2 selection rule with its own rotation, and the rotation advances only on a handshake. While `disp_ready` is low, the offer remains and no group is allocated.
- R9: Each handshake adds one group to the count of `disp_tid`. Each retire pulse removes one group, and a retire on a zero count is ignored. The two counts together never exceed 20. No dispatch is offered while the buffer is full.
- R10: A priority write takes effect in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prio_wr_en | input | 2 | Per-thread priority write strobe |
| prio_wr_data | input | 6 | New priorities, thread t in bits [3t+2:3t] |
| thresh_wr_en | input | 1 | Threshold write strobe |
| thresh_wr_data | input | 5 | New group-count threshold |
| l2_miss_cnt | input | 8 | Outstanding L2 misses, thread t in bits [4t+3:4t] |
| longlat_start | input | 2 | Long-latency operation issued, per thread |
| longlat_done | input | 2 | Long-latency operation complete, per thread |
| grp_avail | input | 2 | Thread has a decoded group ready |
| grp_retire | input | 2 | Thread retires one group |
| fetch_vld | output | 1 | A thread is granted fetch this cycle |
| fetch_tid | output | 1 | Granted fetch thread |
| dec_en | output | 2 | Decode permitted, per thread |
| disp_valid | output | 1 | Dispatch group offered |
| disp_ready | input | 1 | Downstream accepts the offered group |
| disp_tid | output | 1 | Thread of the offered group |
| flush_vld | output | 1 | Partial-flush request pulse |
| flush_tid | output | 1 | Thread to flush |

## Verification
The properties assume the following about the inputs. A retire arrives only for groups that were dispatched. Long-latency start and done pulses are single-cycle events. Miss counts are plain levels. The bench keeps to these assumptions: it issues retires only after it has counted handshakes, it drives every start or done pulse for exactly one cycle, and it changes the miss counts only between sampled cycles. The ROB-full and throttle boundaries are reached only through real handshakes, so the occupancy invariants are exercised on counts that the block built itself.

// File: rtl/smt_ctl_pkg.sv
package smt_ctl_pkg;
  localparam int NUM_THR = 2;
  localparam int TID_W   = 1;
  typedef logic [TID_W-1:0] tid_t;
endpackage

// File: rtl/smt_pair_arb.sv
// Two-way selector: higher effective priority wins, ties rotate.
module smt_pair_arb
  import smt_ctl_pkg::*;
#(
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        req,
  input  logic [PRIO_W-1:0] eff0,
  input  logic [PRIO_W-1:0] eff1,
  input  logic              adv,
  output logic              gnt_vld,
  output tid_t              gnt_tid
);
  tid_t last_q;

  always_comb begin
    gnt_vld = |req;
    gnt_tid = '0;
    unique case (req)
      2'b01:   gnt_tid = 1'b0;
      2'b10:   gnt_tid = 1'b1;
      2'b11: begin
        if (eff0 > eff1)      gnt_tid = 1'b0;
        else if (eff1 > eff0) gnt_tid = 1'b1;
        else                  gnt_tid = ~last_q;
      end
      default: gnt_tid = '0;
    endcase
  end

  // reset to 1 so the first tie goes to thread 0
  always_ff @(posedge clk) begin
    if (!rst_n)              last_q <= 1'b1;
    else if (adv && gnt_vld) last_q <= gnt_tid;
  end
endmodule

// File: rtl/smt_thr_state.sv
// Per-thread state: priority, group count, stall and pending flush.
module smt_thr_state #(
  parameter int PRIO_W   = 3,
  parameter int OCC_W    = 5,
  parameter int RST_PRIO = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prio_we,
  input  logic [PRIO_W-1:0] prio_wd,
  input  logic              alloc,
  input  logic              retire,
  input  logic              ll_start,
  input  logic              ll_done,
  input  logic              flush_ack,
  output logic [PRIO_W-1:0] prio,
  output logic [OCC_W-1:0]  occ,
  output logic              stall,
  output logic              flush_pend
);
  logic dec_ok;
  assign dec_ok = retire && (occ != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio       <= PRIO_W'(RST_PRIO);
      occ        <= '0;
      stall      <= 1'b0;
      flush_pend <= 1'b0;
    end else begin
      if (prio_we) prio <= prio_wd;
      if (alloc && !dec_ok)      occ <= occ + 1'b1;
      else if (!alloc && dec_ok) occ <= occ - 1'b1;
      if (ll_start)     stall <= 1'b1;
      else if (ll_done) stall <= 1'b0;
      if (ll_start)       flush_pend <= 1'b1;
      else if (flush_ack) flush_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/smt_thread_ctl.sv
module smt_thread_ctl
  import smt_ctl_pkg::*;
#(
  parameter int PRIO_W     = 3,
  parameter int MISS_W     = 4,
  parameter int ROB_GROUPS = 20,
  parameter int THRESH_RST = 12,
  parameter int PRIO_RST   = 4,
  localparam int OCC_W     = $clog2(ROB_GROUPS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_THR-1:0]         prio_wr_en,
  input  logic [NUM_THR*PRIO_W-1:0]  prio_wr_data,
  input  logic                       thresh_wr_en,
  input  logic [OCC_W-1:0]           thresh_wr_data,
  input  logic [NUM_THR*MISS_W-1:0]  l2_miss_cnt,
  input  logic [NUM_THR-1:0]         longlat_start,
  input  logic [NUM_THR-1:0]         longlat_done,
  input  logic [NUM_THR-1:0]         grp_avail,
  input  logic [NUM_THR-1:0]         grp_retire,
  output logic                       fetch_vld,
  output tid_t                       fetch_tid,
  output logic [NUM_THR-1:0]         dec_en,
  output logic                       disp_valid,
  input  logic                       disp_ready,
  output tid_t                       disp_tid,
  output logic                       flush_vld,
  output tid_t                       flush_tid
);
  localparam logic [OCC_W:0] ROB_LIM = (OCC_W+1)'(ROB_GROUPS);

  logic [OCC_W-1:0]          thresh_q;
  logic [NUM_THR*PRIO_W-1:0] prio_flat;
  logic [NUM_THR*OCC_W-1:0]  occ_flat;
  logic [PRIO_W-1:0]         eff [NUM_THR];
  logic [NUM_THR-1:0]        stall, pend, ack, alloc, fetch_req, disp_req;
  logic [OCC_W:0]            occ_sum;
  logic                      room, disp_hs;

  always_ff @(posedge clk) begin
    if (!rst_n)            thresh_q <= OCC_W'(THRESH_RST);
    else if (thresh_wr_en) thresh_q <= thresh_wr_data;
  end

  assign disp_hs = disp_valid && disp_ready;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    logic [PRIO_W-1:0] prio;
    logic [OCC_W-1:0]  occ;

    assign alloc[t] = disp_hs && (disp_tid == TID_W'(t));
    assign ack[t]   = flush_vld && (flush_tid == TID_W'(t));

    smt_thr_state #(
      .PRIO_W(PRIO_W), .OCC_W(OCC_W), .RST_PRIO(PRIO_RST)
    ) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .prio_we   (prio_wr_en[t]),
      .prio_wd   (prio_wr_data[t*PRIO_W +: PRIO_W]),
      .alloc     (alloc[t]),
      .retire    (grp_retire[t]),
      .ll_start  (longlat_start[t]),
      .ll_done   (longlat_done[t]),
      .flush_ack (ack[t]),
      .prio      (prio),
      .occ       (occ),
      .stall     (stall[t]),
      .flush_pend(pend[t])
    );

    assign prio_flat[t*PRIO_W +: PRIO_W] = prio;
    assign occ_flat[t*OCC_W +: OCC_W]    = occ;
    // throttled thread falls to the lowest live priority
    assign eff[t]       = (occ > thresh_q) ? PRIO_W'(1) : prio;
    assign fetch_req[t] = (prio != '0);
    assign dec_en[t]    = (prio != '0) && (l2_miss_cnt[t*MISS_W +: MISS_W] == '0) && !stall[t];
    assign disp_req[t]  = dec_en[t] && grp_avail[t] && room;
  end

  assign occ_sum = {1'b0, occ_flat[0 +: OCC_W]} + {1'b0, occ_flat[OCC_W +: OCC_W]};
  assign room    = (occ_sum < ROB_LIM);

  smt_pair_arb #(.PRIO_W(PRIO_W)) u_fetch_arb (
    .clk(clk), .rst_n(rst_n), .req(fetch_req),
    .eff0(eff[0]), .eff1(eff[1]), .adv(1'b1),
    .gnt_vld(fetch_vld), .gnt_tid(fetch_tid)
  );

  smt_pair_arb #(.PRIO_W(PRIO_W)) u_disp_arb (
    .clk(clk), .rst_n(rst_n), .req(disp_req),
    .eff0(eff[0]), .eff1(eff[1]), .adv(disp_ready),
    .gnt_vld(disp_valid), .gnt_tid(disp_tid)
  );

  // thread 0 flush first when both are pending
  assign flush_vld = |pend;
  assign flush_tid = pend[0] ? TID_W'(0) : TID_W'(1);
endmodule

// File: rtl/smt_thread_ctl_chk.sv
module smt_thread_ctl_chk
  import smt_ctl_pkg::*;
#(
  parameter int PRIO_W     = 3,
  parameter int MISS_W     = 4,
  parameter int OCC_W      = 5,
  parameter int ROB_GROUPS = 20
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      fetch_vld,
  input tid_t                      fetch_tid,
  input logic [NUM_THR-1:0]        dec_en,
  input logic                      disp_valid,
  input logic                      disp_ready,
  input tid_t                      disp_tid,
  input logic                      flush_vld,
  input tid_t                      flush_tid,
  input logic [NUM_THR-1:0]        longlat_start,
  input logic [NUM_THR*MISS_W-1:0] l2_miss_cnt,
  input logic [NUM_THR*PRIO_W-1:0] prio_flat,
  input logic [NUM_THR*OCC_W-1:0]  occ_flat
);
  logic [OCC_W:0] sum;
  logic           any_live;
  assign sum      = {1'b0, occ_flat[0 +: OCC_W]} + {1'b0, occ_flat[OCC_W +: OCC_W]};
  assign any_live = (prio_flat[0 +: PRIO_W] != '0) || (prio_flat[PRIO_W +: PRIO_W] != '0);

  a_r1_grant_live: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_vld |-> (prio_flat[fetch_tid*PRIO_W +: PRIO_W] != '0));
  a_r1_grant_present: assert property (@(posedge clk) disable iff (!rst_n)
    any_live |-> fetch_vld);
  a_r8_disp_decodable: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> dec_en[disp_tid]);
  a_r9_rob_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sum <= (OCC_W+1)'(ROB_GROUPS));
  a_r9_full_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sum == (OCC_W+1)'(ROB_GROUPS)) |-> !disp_valid);

  for (genvar t = 0; t < NUM_THR; t++) begin : g_t
    a_r5_miss_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (l2_miss_cnt[t*MISS_W +: MISS_W] != '0) |-> !dec_en[t]);
    a_r6_stall_next: assert property (@(posedge clk) disable iff (!rst_n)
      longlat_start[t] |=> !dec_en[t]);
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_vld && flush_tid == TID_W'(t) && !longlat_start[t])
        |=> !(flush_vld && flush_tid == TID_W'(t)));
  end
endmodule

bind smt_thread_ctl smt_thread_ctl_chk #(
  .PRIO_W(PRIO_W), .MISS_W(MISS_W), .OCC_W(OCC_W), .ROB_GROUPS(ROB_GROUPS)
) u_chk (.*);

// File: tb/smt_thread_ctl_tb.sv
module smt_thread_ctl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] prio_wr_en;
  logic [5:0] prio_wr_data;
  logic       thresh_wr_en;
  logic [4:0] thresh_wr_data;
  logic [7:0] l2_miss_cnt;
  logic [1:0] longlat_start, longlat_done, grp_avail, grp_retire;
  logic       fetch_vld, fetch_tid, disp_valid, disp_ready, disp_tid, flush_vld, flush_tid;
  logic [1:0] dec_en;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  smt_thread_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .prio_wr_en(prio_wr_en), .prio_wr_data(prio_wr_data),
    .thresh_wr_en(thresh_wr_en), .thresh_wr_data(thresh_wr_data),
    .l2_miss_cnt(l2_miss_cnt), .longlat_start(longlat_start), .longlat_done(longlat_done),
    .grp_avail(grp_avail), .grp_retire(grp_retire), .fetch_vld(fetch_vld),
    .fetch_tid(fetch_tid), .dec_en(dec_en), .disp_valid(disp_valid),
    .disp_ready(disp_ready), .disp_tid(disp_tid), .flush_vld(flush_vld),
    .flush_tid(flush_tid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    prio_wr_en = '0; prio_wr_data = '0; thresh_wr_en = 1'b0; thresh_wr_data = '0;
    l2_miss_cnt = '0; longlat_start = '0; longlat_done = '0;
    grp_avail = '0; grp_retire = '0; disp_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic set_prio(input int p0, input int p1);
    @(negedge clk);
    prio_wr_en = 2'b11;
    prio_wr_data = {3'(p1), 3'(p0)};
    @(negedge clk);
    prio_wr_en = '0;
    #1;
  endtask

  // offer n handshakes with ready held high
  task automatic dispatch_n(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      disp_ready = 1'b1;
      #1;
      chk("R8 offer during fill", int'(disp_valid), 1);
    end
    @(negedge clk);
    disp_ready = 1'b0;
    #1;
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int g1v, g1t, g2v, g2t, ev, et, hs, hs0, hs1;
    do_reset();
    // R3 reset state, R2 first tie to thread 0
    chk("R3 fetch valid", int'(fetch_vld), 1);
    chk("R2 first tie tid", int'(fetch_tid), 0);
    chk("R3 decode enables", int'(dec_en), 3);
    chk("R3 no flush", int'(flush_vld), 0);
    chk("R3 no dispatch", int'(disp_valid), 0);
    step();
    chk("R2 tie alternates", int'(fetch_tid), 1);

    // R1/R2/R10 priority sweep
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        set_prio(a, b);
        g1v = int'(fetch_vld); g1t = int'(fetch_tid);
        chk("R5 prio-zero decode gate", int'(dec_en), ((b != 0) ? 2 : 0) + ((a != 0) ? 1 : 0));
        step();
        g2v = int'(fetch_vld); g2t = int'(fetch_tid);
        ev = (a != 0 || b != 0) ? 1 : 0;
        chk("R1 grant presence", g1v, ev);
        chk("R1 grant presence 2", g2v, ev);
        if (ev == 1) begin
          if (a == b) chk("R2 tie rotation", int'(g1t != g2t), 1);
          else begin
            et = (a > b) ? 0 : 1;
            chk("R2 higher wins", g1t, et);
            chk("R2 higher wins 2", g2t, et);
          end
        end
      end
    end

    // R5 miss gating sweep
    set_prio(4, 4);
    for (int m0 = 0; m0 < 4; m0++) begin
      for (int m1 = 0; m1 < 4; m1++) begin
        @(negedge clk);
        l2_miss_cnt = {4'(m1), 4'(m0)};
        #1;
        chk("R5 miss gate", int'(dec_en), ((m1 == 0) ? 2 : 0) + ((m0 == 0) ? 1 : 0));
      end
    end
    @(negedge clk); l2_miss_cnt = '0;

    // R6/R7 single long-latency op on thread 0
    @(negedge clk); longlat_start = 2'b01;
    @(negedge clk); longlat_start = 2'b00; #1;
    chk("R7 flush pulse", int'(flush_vld), 1);
    chk("R7 flush tid", int'(flush_tid), 0);
    chk("R6 stall t0", int'(dec_en), 2);
    step();
    chk("R7 pulse ends", int'(flush_vld), 0);
    repeat (3) begin step(); chk("R6 stall held", int'(dec_en[0]), 0); end
    @(negedge clk); longlat_done = 2'b01; #1;
    chk("R6 done not yet seen", int'(dec_en[0]), 0);
    @(negedge clk); longlat_done = 2'b00; #1;
    chk("R6 decode resumes", int'(dec_en), 3);

    // R7 both threads together
    @(negedge clk); longlat_start = 2'b11;
    @(negedge clk); longlat_start = 2'b00; #1;
    chk("R7 first flush", int'(flush_vld) * 2 + int'(flush_tid), 2);
    chk("R6 both stalled", int'(dec_en), 0);
    step();
    chk("R7 second flush", int'(flush_vld) * 2 + int'(flush_tid), 3);
    step();
    chk("R7 flushes done", int'(flush_vld), 0);
    @(negedge clk); longlat_done = 2'b11;
    @(negedge clk); longlat_done = 2'b00; #1;
    chk("R6 both resume", int'(dec_en), 3);

    // R6 start wins over simultaneous done
    @(negedge clk); longlat_start = 2'b10; longlat_done = 2'b10;
    @(negedge clk); longlat_start = 2'b00; longlat_done = 2'b00; #1;
    chk("R6 start wins", int'(dec_en[1]), 0);
    @(negedge clk); longlat_done = 2'b10;
    @(negedge clk); longlat_done = 2'b00; #1;
    chk("R6 clear after done", int'(dec_en[1]), 1);

    // R8 dispatch gated by decode
    do_reset();
    @(negedge clk); grp_avail = 2'b11; l2_miss_cnt = 8'h02; #1;
    chk("R8 only decodable thread", int'(disp_valid) * 2 + int'(disp_tid), 3);
    @(negedge clk); l2_miss_cnt = '0;

    // R9 retire at zero ignored, then fill to the limit
    @(negedge clk); grp_retire = 2'b10;
    @(negedge clk); grp_retire = 2'b00;
    hs = 0; hs0 = 0; hs1 = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      disp_ready = 1'b1;
      #1;
      if (disp_valid) begin
        hs++;
        if (disp_tid) hs1++; else hs0++;
      end
    end
    @(negedge clk); disp_ready = 1'b0; #1;
    chk("R9 total groups", hs, 20);
    chk("R2 tie split thread0", hs0, 10);
    chk("R2 tie split thread1", hs1, 10);
    chk("R9 full no offer", int'(disp_valid), 0);
    @(negedge clk); grp_retire = 2'b01; #1;
    chk("R9 retire not yet applied", int'(disp_valid), 0);
    @(negedge clk); grp_retire = 2'b00; #1;
    chk("R9 slot freed", int'(disp_valid), 1);
    repeat (3) begin step(); chk("R8 offer held under backpressure", int'(disp_valid), 1); end
    @(negedge clk); disp_ready = 1'b1;
    @(negedge clk); disp_ready = 1'b0; #1;
    chk("R9 full again", int'(disp_valid), 0);

    // R4 throttling with default threshold 12
    do_reset();
    set_prio(7, 3);
    @(negedge clk); grp_avail = 2'b01;
    dispatch_n(12);
    chk("R4 at threshold not throttled", int'(fetch_tid), 0);
    dispatch_n(1);
    chk("R3 default threshold throttles", int'(fetch_tid), 1);
    step();
    chk("R4 throttled stays low", int'(fetch_tid), 1);
    @(negedge clk); thresh_wr_en = 1'b1; thresh_wr_data = 5'd13; #1;
    chk("R4 write not yet active", int'(fetch_tid), 1);
    @(negedge clk); thresh_wr_en = 1'b0; #1;
    chk("R4 raised threshold", int'(fetch_tid), 0);
    @(negedge clk); grp_avail = 2'b00;
    set_prio(7, 1);
    @(negedge clk); thresh_wr_en = 1'b1; thresh_wr_data = 5'd2;
    @(negedge clk); thresh_wr_en = 1'b0; #1;
    g1t = int'(fetch_tid);
    step();
    chk("R4 throttled ties rotate", int'(g1t != int'(fetch_tid)), 1);

    // R10 write latency
    @(negedge clk); prio_wr_en = 2'b11; prio_wr_data = {3'd0, 3'd0}; #1;
    chk("R10 old priority still live", int'(fetch_vld), 1);
    @(negedge clk); prio_wr_en = '0; #1;
    chk("R10 new priority applied", int'(fetch_vld), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule